// File: doc/BRIEF.md
# Rectified Moving-Average Detector

This block turns a stream of wide signed samples, such as the output of a long FIR filter, into a smoothed level. It acts on each sample that arrives with its valid strobe. It takes the absolute value of the sample and drops a fixed number of low bits, which leaves a narrow unsigned scaled magnitude. It then averages the most recent 2^DEPTH_LG of these magnitudes. The result is large when a tone passes through the filter and small when the filter blocks it.

A single memory acts as a circular window. In each update the entry under the write pointer is read out as the value that leaves the window, and the new scaled value is written in its place. A running sum adds the new value and subtracts the one that leaves. The average is the upper part of that sum, which is the sum divided by the window length. Slots that have not been written since reset count as zero.

Top module: `rmad_detector`

## Requirements
- R1: After reset is released, avg_o is 0 and valid_o is 0.
- R2: valid_o is high for exactly the one cycle after each cycle in which valid_i is high, and low at all other times.
- R3: While valid_i is low, data_i has no effect: avg_o holds its value and the state of the window does not change.
- R4: The scaled value of a sample is floor(|data_i| / 2^SHIFT), with data_i read as two's complement, for both positive and negative samples.
- R5: The most negative input is treated as the largest positive magnitude, 2^(IN_W-1)-1. With the default parameters its scaled value is 32767.
- R6: Before 2^DEPTH_LG samples have arrived since reset, slots not yet written count as zero. avg_o equals floor(sum of all samples received / 2^DEPTH_LG).
- R7: Once the window is full, each new sample replaces the oldest one. avg_o equals floor(sum of the last 2^DEPTH_LG scaled values / 2^DEPTH_LG).
- R8: The running sum does not overflow. A window filled with the largest scaled value gives avg_o = 32767, and avg_o never exceeds 2^(IN_W-1-SHIFT)-1.
- R9: avg_o changes only in the cycle in which valid_o is high.
- R10: Asserting reset during operation clears the history. The first sample after reset is averaged as if the window held only that sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | IN_W (44) | Signed sample |
| valid_i | input | 1 | Sample strobe |
| avg_o | output | IN_W-SHIFT (16) | Windowed average of scaled magnitudes |
| valid_o | output | 1 | High for one cycle after each accepted sample |

## Verification
The bench checks the start of operation, when the window is only partly filled. A design that used uncleared memory there would produce a garbage average. The bench also checks the first wrap of the window: a design with an off-by-one eviction would drift away from the directly summed reference.

It checks the most negative input, which a plain two's-complement negate turns into a huge magnitude or a zero. It fills the whole window with the largest value, which shows whether the accumulator is too narrow and wraps. Finally, it feeds garbage with the strobe low and then resets during operation, which shows whether the block acts on unqualified data or keeps stale history after reset.

// File: rtl/rmad_pkg.sv
package rmad_pkg;
  localparam int unsigned IN_W_DEF     = 44;
  localparam int unsigned SHIFT_DEF    = 28;
  localparam int unsigned DEPTH_LG_DEF = 10;
endpackage

// File: rtl/rmad_rectify.sv
module rmad_rectify #(
  parameter int unsigned IN_W  = rmad_pkg::IN_W_DEF,
  parameter int unsigned SHIFT = rmad_pkg::SHIFT_DEF,
  localparam int unsigned SCL_W = IN_W - SHIFT
) (
  input  logic [IN_W-1:0]  data_i,
  output logic [SCL_W-1:0] scl_o
);
  logic            neg;
  logic            is_min;
  logic [IN_W-1:0] mag;

  assign neg    = data_i[IN_W-1];
  assign is_min = neg && ~|data_i[IN_W-2:0];

  always_comb begin
    if (is_min)   mag = {1'b0, {(IN_W-1){1'b1}}};  // saturate
    else if (neg) mag = ~data_i + 1'b1;
    else          mag = data_i;
  end

  assign scl_o = mag[IN_W-1:SHIFT];
endmodule

// File: rtl/rmad_ring.sv
module rmad_ring #(
  parameter int unsigned W  = 16,
  parameter int unsigned LG = rmad_pkg::DEPTH_LG_DEF,
  localparam int unsigned DEPTH = 1 << LG
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] old_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [LG-1:0] ptr_q;
  logic          full_q;

  // unwritten slots read as zero until first wrap
  assign old_o = full_q ? mem[ptr_q] : '0;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
    end else if (wr_en_i) begin
      ptr_q <= ptr_q + 1'b1;
      if (&ptr_q) full_q <= 1'b1;
    end
  end
endmodule

// File: rtl/rmad_accum.sv
module rmad_accum #(
  parameter int unsigned W  = 16,
  parameter int unsigned LG = rmad_pkg::DEPTH_LG_DEF,
  localparam int unsigned SUM_W = W + LG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [W-1:0]     add_i,
  input  logic [W-1:0]     sub_i,
  output logic [SUM_W-1:0] sum_o,
  output logic [W-1:0]     avg_o,
  output logic             valid_o
);
  logic [SUM_W-1:0] sum_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= upd_i;
      if (upd_i) sum_q <= sum_q + SUM_W'(add_i) - SUM_W'(sub_i);
    end
  end

  assign sum_o   = sum_q;
  assign avg_o   = sum_q[SUM_W-1:LG];
  assign valid_o = vld_q;
endmodule

// File: rtl/rmad_detector.sv
module rmad_detector #(
  parameter int unsigned IN_W     = rmad_pkg::IN_W_DEF,
  parameter int unsigned SHIFT    = rmad_pkg::SHIFT_DEF,
  parameter int unsigned DEPTH_LG = rmad_pkg::DEPTH_LG_DEF,
  localparam int unsigned SCL_W   = IN_W - SHIFT,
  localparam int unsigned SUM_W   = SCL_W + DEPTH_LG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  data_i,
  input  logic             valid_i,
  output logic [SCL_W-1:0] avg_o,
  output logic             valid_o
);
  logic [SCL_W-1:0] scl;
  logic [SCL_W-1:0] old;
  logic [SUM_W-1:0] sum;

  rmad_rectify #(.IN_W(IN_W), .SHIFT(SHIFT)) u_rect (
    .data_i (data_i),
    .scl_o  (scl)
  );

  rmad_ring #(.W(SCL_W), .LG(DEPTH_LG)) u_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (valid_i),
    .wr_data_i (scl),
    .old_o     (old)
  );

  rmad_accum #(.W(SCL_W), .LG(DEPTH_LG)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (valid_i),
    .add_i   (scl),
    .sub_i   (old),
    .sum_o   (sum),
    .avg_o   (avg_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/rmad_detector_chk.sv
module rmad_detector_chk #(
  parameter int unsigned IN_W     = rmad_pkg::IN_W_DEF,
  parameter int unsigned SHIFT    = rmad_pkg::SHIFT_DEF,
  parameter int unsigned DEPTH_LG = rmad_pkg::DEPTH_LG_DEF,
  localparam int unsigned SCL_W   = IN_W - SHIFT
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IN_W-1:0]  data_i,
  input logic             valid_i,
  input logic [SCL_W-1:0] avg_o,
  input logic             valid_o,
  input logic [SCL_W-1:0] scl
);
  localparam logic [IN_W-1:0]  IN_MIN  = {1'b1, {(IN_W-1){1'b0}}};
  localparam logic [SCL_W-1:0] SCL_MAX = {1'b0, {(SCL_W-1){1'b1}}};

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(avg_o));  // R3
  AST_SAT_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && data_i == IN_MIN) |-> scl == SCL_MAX);  // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> avg_o <= SCL_MAX);  // R8
  AST_CHANGE_ON_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(avg_o));  // R9
endmodule

bind rmad_detector rmad_detector_chk #(
  .IN_W(IN_W), .SHIFT(SHIFT), .DEPTH_LG(DEPTH_LG)
) u_chk (.*);

// File: tb/rmad_detector_bench.sv
module rmad_detector_bench;
  localparam int IN_W  = 44;
  localparam int SHIFT = 28;
  localparam int LG    = 10;
  localparam int DEPTH = 1 << LG;
  localparam int SW    = IN_W - SHIFT;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic [IN_W-1:0] data_i;
  logic            valid_i;
  logic [SW-1:0]   avg_o;
  logic            valid_o;

  int n_chk = 0;
  int n_fail = 0;

  longint ref_win [DEPTH];
  int     ref_ptr;

  always #5 clk_i = ~clk_i;

  rmad_detector u_rmad_detector (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .valid_i(valid_i),
    .avg_o(avg_o), .valid_o(valid_o)
  );

  // sample, expected average from reset (first rows, worked by hand)
  localparam int NV = 6;
  localparam logic signed [IN_W-1:0] VEC_D [NV] = '{
    44'sd274877906944,    // scaled 1024 -> avg 1
    -44'sd549755813888,   // scaled 2048 -> avg 3
    44'sd1610612735,      // scaled 5    -> avg 3
    -44'sd268435455,      // scaled 0    -> avg 3
    -44'sd8796093022208,  // min, 32767  -> avg 35
    44'sd274072600576     // scaled 1021 -> avg 36
  };
  localparam int VEC_A [NV] = '{1, 3, 3, 3, 35, 36};

  function automatic longint scale_of(logic [IN_W-1:0] d);
    longint v;
    v = longint'($signed(d));
    if (v == -(64'sd1 <<< (IN_W-1))) v = (64'sd1 <<< (IN_W-1)) - 1;
    else if (v < 0) v = -v;
    return v >>> SHIFT;
  endfunction

  function automatic longint ref_avg();
    longint s = 0;
    for (int i = 0; i < DEPTH; i++) s += ref_win[i];
    return s >>> LG;
  endfunction

  task automatic ref_clear();
    for (int i = 0; i < DEPTH; i++) ref_win[i] = 0;
    ref_ptr = 0;
  endtask

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one sample, then sample outputs one cycle later, away from edge
  task automatic send(logic [IN_W-1:0] d, string req, bit use_exp, longint exp);
    @(negedge clk_i);
    data_i  = d;
    valid_i = 1'b1;
    ref_win[ref_ptr] = scale_of(d);
    ref_ptr = (ref_ptr + 1) % DEPTH;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R2", longint'(valid_o), 1);
    check(req, longint'(avg_o), use_exp ? exp : ref_avg());
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    ref_clear();
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] lfsr;
    logic [SW-1:0] hold;
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    data_i  = '0;
    ref_clear();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", longint'(avg_o), 0);
    check("R1", longint'(valid_o), 0);

    // vector table: R4 R5 R6
    for (int i = 0; i < NV; i++) send(VEC_D[i], "R4/R6", 1'b1, longint'(VEC_A[i]));

    // pseudo-random run past the first wrap: R6 then R7
    lfsr = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 2 * DEPTH + 100; i++) begin
      lfsr ^= lfsr << 13;
      lfsr ^= lfsr >> 7;
      lfsr ^= lfsr << 17;
      send(lfsr[IN_W-1:0], (i < DEPTH) ? "R6" : "R7", 1'b0, 0);
    end

    // strobe low, garbage data: R3 R9
    hold = avg_o;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      data_i = {IN_W{i[0]}} ^ 44'h5A5_A5A5_A5A5;
      check("R3", longint'(avg_o), longint'(hold));
      check("R9", longint'(valid_o), 0);
    end
    send(44'sd268435456 * 7, "R3", 1'b0, 0);

    // full window of most negative input: R5 R8
    for (int i = 0; i < DEPTH; i++) send({1'b1, {(IN_W-1){1'b0}}}, "R8", 1'b0, 0);
    check("R8", longint'(avg_o), 32767);

    // reset during operation: R10
    do_reset();
    check("R10", longint'(avg_o), 0);
    check("R10", longint'(valid_o), 0);
    send(-44'sd549755813888, "R10", 1'b1, 2);
    send(44'sd274877906944 * 4, "R10", 1'b1, 6);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule